// File: doc/BRIEF.md
# Framed Timeslot Bit Extractor

This block pulls the bits of a low-rate data link out of a framed serial line stream, ready for an HDLC receiver. On every bit-clock enable it samples one recovered line bit. A frame-start strobe marks that bit as position 0 of a frame. From that strobe the block keeps its own count of frame parity, timeslot and bit-in-timeslot. It passes a line bit on when every condition below holds:

- the receive gate is open;
- the frame's parity is one of those selected;
- the bit lies in the chosen timeslot;
- the bit's mask bit is set.

Two frame formats are supported. The first has 32 timeslots of 8 bits. The second has one framing bit followed by 24 channels of 8 bits.

A bypass mode exists for framings that fix the link position themselves. In that mode an external fixed-position strobe marks the link bits, and the parity, timeslot and mask settings play no part. All configuration is copied into shadow registers on the frame-start strobe, so a frame is always extracted under a single setting. The extracted stream leaves the block through a registered data bit and a one-cycle valid strobe.

Top module: `ts_bit_extract`

## Requirements
- R1: After reset `ext_valid` and `ext_bit` are 0, and no bit is extracted before the first sampled frame-start strobe, whatever the configuration.
- R2: A line bit sampled at a clock edge with `bit_en`=1 and selected for extraction appears one cycle later as `ext_bit`, with `ext_valid` high for exactly that cycle. `ext_valid` is never high unless `bit_en` was 1 at the previous edge, and `ext_bit` holds its value while `ext_valid` is low.
- R3: The first frame after reset is frame 0 (even), and parity toggles on every sampled frame-start strobe. Bits are taken only from even frames when `cfg_even`=1, only from odd frames when `cfg_odd`=1, from all frames when both are set, and from no frame when neither is set.
- R4: With `cfg_t1`=0 a frame has 256 bit positions, numbered from 0 at the frame-start bit. Timeslot k occupies positions 8k to 8k+7, and only timeslot `cfg_slot` is extracted.
- R5: Within the chosen timeslot, mask bit 7 of `cfg_mask` governs the first bit received and mask bit 0 the last. A bit whose mask bit is 0 is skipped.
- R6: With `cfg_t1`=1 position 0 is a framing bit that is never extracted. Channel k occupies positions 1+8k to 8+8k for k = 0..23, and a `cfg_slot` of 24 or above extracts nothing.
- R7: With `cfg_rx_en`=0 nothing is extracted.
- R8: With `cfg_fixed`=1 a bit is extracted exactly when `fixed_strobe` is 1 at a `bit_en` edge (receive gate open). Parity, timeslot and mask are ignored in this mode.
- R9: Configuration inputs take effect only at the next sampled frame-start strobe. A change in the middle of a frame leaves the rest of that frame unaffected.
- R10: Clock cycles with `bit_en`=0 neither advance the position nor extract anything.
- R11: If no frame-start strobe arrives, the position wraps after the last bit of the frame (256 or 193 positions) and extraction continues with unchanged parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit clock enable; one line bit per asserted cycle |
| line_bit | input | 1 | Recovered line data bit |
| frame_start | input | 1 | Marks the current bit as position 0 of a frame (valid with bit_en) |
| fixed_strobe | input | 1 | Bypass-mode link bit marker (valid with bit_en) |
| cfg_rx_en | input | 1 | Receive gate |
| cfg_even | input | 1 | Use even frames |
| cfg_odd | input | 1 | Use odd frames |
| cfg_t1 | input | 1 | 0: 32x8 frame, 1: framing bit plus 24x8 |
| cfg_fixed | input | 1 | Bypass mode using fixed_strobe |
| cfg_slot | input | 5 | Timeslot / channel index |
| cfg_mask | input | 8 | Per-bit enable, bit 7 = first bit of timeslot |
| ext_bit | output | 1 | Extracted data bit |
| ext_valid | output | 1 | Extracted bit strobe |

## Verification
The extractor is driven with random line data under several patterns:

- A full mask in a middle timeslot, and a sparse mask in the last timeslot. These separate timeslot decoding from the ordering of the mask bits.
- Even-only, odd-only and neither parity settings. These show whether parity starts at even and toggles per frame.
- Gapped bit enables, and the 193-bit format with its framing bit. These show that the position counter advances only on enabled bits and skips the framing bit.
- Bypass mode with a periodic fixed strobe and unselected parity. This separates the fixed-position path from the timeslot path.
- A timeslot change in mid-frame toward a timeslot that has already passed. This distinguishes shadowed configuration from live configuration.
- A frame left without its start strobe. This exercises the wrap at the end of the frame.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int unsigned SLOT_BITS  = 8;
  localparam int unsigned BIT_IDX_W  = $clog2(SLOT_BITS);
  localparam int unsigned SLOT_IDX_W = 5;

  typedef struct packed {
    logic                  rx_en;
    logic                  even;
    logic                  odd;
    logic                  t1;
    logic                  fixed;
    logic [SLOT_IDX_W-1:0] slot;
    logic [SLOT_BITS-1:0]  mask;
  } cfg_t;
endpackage

// File: rtl/tsx_cfg_shadow.sv
module tsx_cfg_shadow
  import tsx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cfg_t cfg_live,
  output cfg_t cfg_eff
);
  cfg_t shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (load) begin
      shadow_q <= cfg_live;
    end
  end

  // The bit carrying the frame-start strobe already belongs to the new frame.
  always_comb begin
    cfg_eff = load ? cfg_live : shadow_q;
  end
endmodule

// File: rtl/tsx_pos_track.sv
module tsx_pos_track
  import tsx_pkg::*;
#(
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned T1_SLOTS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  frame_start,
  input  logic                  t1_fmt,
  output logic                  cur_sync,
  output logic                  cur_par,
  output logic                  cur_fbit,
  output logic [SLOT_IDX_W-1:0] cur_slot,
  output logic [BIT_IDX_W-1:0]  cur_bit
);
  localparam logic [SLOT_IDX_W-1:0] E1_LAST  = SLOT_IDX_W'(E1_SLOTS - 1);
  localparam logic [SLOT_IDX_W-1:0] T1_LAST  = SLOT_IDX_W'(T1_SLOTS - 1);
  localparam logic [BIT_IDX_W-1:0]  BIT_LAST = BIT_IDX_W'(SLOT_BITS - 1);

  logic                  sync_q;
  logic                  par_q;
  logic                  fbit_q;
  logic [SLOT_IDX_W-1:0] slot_q;
  logic [BIT_IDX_W-1:0]  bit_q;
  logic [SLOT_IDX_W-1:0] last_slot;

  assign last_slot = t1_fmt ? T1_LAST : E1_LAST;

  // Position of the bit currently on the line: either a fresh frame or one step on.
  always_comb begin
    cur_sync = sync_q;
    cur_par  = par_q;
    cur_fbit = 1'b0;
    cur_slot = slot_q;
    cur_bit  = bit_q;
    if (frame_start) begin
      cur_sync = 1'b1;
      cur_par  = ~par_q;
      cur_fbit = t1_fmt;
      cur_slot = '0;
      cur_bit  = '0;
    end else if (fbit_q) begin
      cur_slot = '0;
      cur_bit  = '0;
    end else if (bit_q == BIT_LAST) begin
      cur_bit = '0;
      if (slot_q == last_slot) begin
        cur_slot = '0;
        cur_fbit = t1_fmt;
      end else begin
        cur_slot = slot_q + 1'b1;
      end
    end else begin
      cur_bit = bit_q + 1'b1;
    end
  end

  // par_q resets to odd so that the first frame-start makes frame 0 even.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      par_q  <= 1'b1;
      fbit_q <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bit_en) begin
      sync_q <= cur_sync;
      par_q  <= cur_par;
      fbit_q <= cur_fbit;
      slot_q <= cur_slot;
      bit_q  <= cur_bit;
    end
  end
endmodule

// File: rtl/tsx_bit_select.sv
module tsx_bit_select
  import tsx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  line_bit,
  input  logic                  fixed_strobe,
  input  cfg_t                  cfg,
  input  logic                  cur_sync,
  input  logic                  cur_par,
  input  logic                  cur_fbit,
  input  logic [SLOT_IDX_W-1:0] cur_slot,
  input  logic [BIT_IDX_W-1:0]  cur_bit,
  output logic                  ext_bit,
  output logic                  ext_valid
);
  localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(SLOT_BITS - 1);

  logic [BIT_IDX_W-1:0] mask_idx;
  logic                 par_ok;
  logic                 slot_hit;
  logic                 pick;

  assign mask_idx = BIT_LAST - cur_bit;
  assign par_ok   = cur_par ? cfg.odd : cfg.even;
  assign slot_hit = !cur_fbit && (cur_slot == cfg.slot) && cfg.mask[mask_idx];

  always_comb begin
    pick = 1'b0;
    if (cur_sync && cfg.rx_en) begin
      if (cfg.fixed) pick = fixed_strobe;
      else           pick = par_ok && slot_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_valid <= 1'b0;
      ext_bit   <= 1'b0;
    end else begin
      ext_valid <= bit_en && pick;
      if (bit_en && pick) ext_bit <= line_bit;
    end
  end
endmodule

// File: rtl/ts_bit_extract.sv
module ts_bit_extract
  import tsx_pkg::*;
#(
  parameter int unsigned E1_SLOTS = 32,
  parameter int unsigned T1_SLOTS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  line_bit,
  input  logic                  frame_start,
  input  logic                  fixed_strobe,
  input  logic                  cfg_rx_en,
  input  logic                  cfg_even,
  input  logic                  cfg_odd,
  input  logic                  cfg_t1,
  input  logic                  cfg_fixed,
  input  logic [SLOT_IDX_W-1:0] cfg_slot,
  input  logic [SLOT_BITS-1:0]  cfg_mask,
  output logic                  ext_bit,
  output logic                  ext_valid
);
  cfg_t                  cfg_live;
  cfg_t                  cfg_eff;
  logic                  fs_take;
  logic                  cur_sync;
  logic                  cur_par;
  logic                  cur_fbit;
  logic [SLOT_IDX_W-1:0] cur_slot;
  logic [BIT_IDX_W-1:0]  cur_bit;

  assign fs_take = bit_en && frame_start;

  always_comb begin
    cfg_live.rx_en = cfg_rx_en;
    cfg_live.even  = cfg_even;
    cfg_live.odd   = cfg_odd;
    cfg_live.t1    = cfg_t1;
    cfg_live.fixed = cfg_fixed;
    cfg_live.slot  = cfg_slot;
    cfg_live.mask  = cfg_mask;
  end

  tsx_cfg_shadow u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (fs_take),
    .cfg_live (cfg_live),
    .cfg_eff  (cfg_eff)
  );

  tsx_pos_track #(
    .E1_SLOTS (E1_SLOTS),
    .T1_SLOTS (T1_SLOTS)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .t1_fmt      (cfg_eff.t1),
    .cur_sync    (cur_sync),
    .cur_par     (cur_par),
    .cur_fbit    (cur_fbit),
    .cur_slot    (cur_slot),
    .cur_bit     (cur_bit)
  );

  tsx_bit_select u_sel (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .line_bit     (line_bit),
    .fixed_strobe (fixed_strobe),
    .cfg          (cfg_eff),
    .cur_sync     (cur_sync),
    .cur_par      (cur_par),
    .cur_fbit     (cur_fbit),
    .cur_slot     (cur_slot),
    .cur_bit      (cur_bit),
    .ext_bit      (ext_bit),
    .ext_valid    (ext_valid)
  );
endmodule

// File: rtl/tsx_checker.sv
module tsx_checker
  import tsx_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic line_bit,
  input logic ext_bit,
  input logic ext_valid,
  input cfg_t eff,
  input logic cur_par,
  input logic cur_fbit
);
  p_valid_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> $past(bit_en));

  p_bit_follows_line_r2: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> (ext_bit == $past(line_bit)));

  p_bit_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !ext_valid |-> $stable(ext_bit));

  p_gate_closed_r7: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> $past(eff.rx_en));

  p_no_framing_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && !$past(eff.fixed)) |-> !$past(cur_fbit));

  p_parity_select_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && !$past(eff.fixed)) |-> ($past(cur_par) ? $past(eff.odd) : $past(eff.even)));
endmodule

bind ts_bit_extract tsx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .line_bit  (line_bit),
  .ext_bit   (ext_bit),
  .ext_valid (ext_valid),
  .eff       (cfg_eff),
  .cur_par   (cur_par),
  .cur_fbit  (cur_fbit)
);

// File: tb/tb_ts_bit_extract.sv
module tb_ts_bit_extract;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, line_bit = 1'b0, frame_start = 1'b0, fixed_strobe = 1'b0;
  logic       cfg_rx_en = 1'b0, cfg_even = 1'b0, cfg_odd = 1'b0, cfg_t1 = 1'b0, cfg_fixed = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_mask = '0;
  logic       ext_bit, ext_valid;

  int checks = 0, errors = 0, vcount = 0;
  int fs_mod = 1000, fs_off = 999;
  string tag = "R1";

  // reference model state
  logic m_valid, m_bit;
  int   m_pos, m_par;
  bit   m_sync, s_en, s_even, s_odd, s_t1, s_fixed;
  int   s_slot;
  logic [7:0] s_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_bit_extract dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_bit(line_bit),
    .frame_start(frame_start), .fixed_strobe(fixed_strobe),
    .cfg_rx_en(cfg_rx_en), .cfg_even(cfg_even), .cfg_odd(cfg_odd),
    .cfg_t1(cfg_t1), .cfg_fixed(cfg_fixed), .cfg_slot(cfg_slot),
    .cfg_mask(cfg_mask), .ext_bit(ext_bit), .ext_valid(ext_valid)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0; m_bit <= 1'b0;
      m_pos = 0; m_par = 1; m_sync = 0; s_en = 0;
    end else begin
      bit sel;
      int slot, bpos, flen;
      sel = 0;
      if (bit_en) begin
        if (frame_start) begin
          m_pos = 0; m_par = 1 - m_par; m_sync = 1;
          s_en = cfg_rx_en; s_even = cfg_even; s_odd = cfg_odd; s_t1 = cfg_t1;
          s_fixed = cfg_fixed; s_slot = cfg_slot; s_mask = cfg_mask;
        end else begin
          flen = s_t1 ? 193 : 256;
          m_pos = (m_pos + 1) % flen;
        end
        if (m_sync && s_en) begin
          if (s_fixed) sel = fixed_strobe;
          else begin
            if (s_t1) begin
              slot = (m_pos == 0) ? -1 : (m_pos - 1) / 8;
              bpos = (m_pos == 0) ? 0 : (m_pos - 1) % 8;
            end else begin
              slot = m_pos / 8;
              bpos = m_pos % 8;
            end
            sel = ((m_par == 0) ? s_even : s_odd) && slot == s_slot && s_mask[7 - bpos];
          end
        end
      end
      m_valid <= sel;
      if (sel) m_bit <= line_bit;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ext_valid !== m_valid || ext_bit !== m_bit) begin
        errors++;
        $display("FAIL %s R2 cycle compare: valid/bit actual %b/%b expected %b/%b",
                 tag, ext_valid, ext_bit, m_valid, m_bit);
      end
      if (ext_valid) vcount++;
    end
  end

  task automatic check_eq(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s extracted count: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input int gap, input bit with_fs,
                           input int chg_at, input int chg_slot);
    for (int i = 0; i < nbits; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1; bit_en = 0; frame_start = 0;
      end
      @(posedge clk); #1;
      bit_en = 1; frame_start = with_fs && (i == 0);
      line_bit = 1'($urandom % 2);
      fixed_strobe = ((i % fs_mod) == fs_off);
      if (i == chg_at) cfg_slot = 5'(chg_slot);
    end
    @(posedge clk); #1; bit_en = 0; frame_start = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic setcfg(input bit en, input bit ev, input bit od, input bit t1,
                        input bit fx, input int sl, input logic [7:0] mk);
    cfg_rx_en = en; cfg_even = ev; cfg_odd = od; cfg_t1 = t1;
    cfg_fixed = fx; cfg_slot = 5'(sl); cfg_mask = mk;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    checks++;
    if (ext_valid !== 1'b0 || ext_bit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b/%b expected 0/0", ext_valid, ext_bit);
    end
    // R1: configured but never framed
    setcfg(1, 1, 1, 0, 0, 0, 8'hFF);
    base = vcount; run_frame(300, 0, 0, -1, 0); check_eq("R1", vcount - base, 0);
    // R4: full timeslot in the middle of the frame
    tag = "R4"; setcfg(1, 1, 1, 0, 0, 5, 8'hFF);
    base = vcount; repeat (2) run_frame(256, 0, 1, -1, 0); check_eq("R4", vcount - base, 16);
    // R5: sparse mask, last timeslot
    tag = "R5"; setcfg(1, 1, 1, 0, 0, 31, 8'hA5);
    base = vcount; repeat (2) run_frame(256, 0, 1, -1, 0); check_eq("R5", vcount - base, 8);
    // R3: parity selection
    tag = "R3"; setcfg(1, 1, 0, 0, 0, 2, 8'hFF);
    base = vcount; repeat (4) run_frame(256, 0, 1, -1, 0); check_eq("R3 even", vcount - base, 16);
    setcfg(1, 0, 1, 0, 0, 2, 8'hFF);
    base = vcount; repeat (4) run_frame(256, 0, 1, -1, 0); check_eq("R3 odd", vcount - base, 16);
    setcfg(1, 0, 0, 0, 0, 2, 8'hFF);
    base = vcount; repeat (2) run_frame(256, 0, 1, -1, 0); check_eq("R3 none", vcount - base, 0);
    // R10: gapped bit enables
    tag = "R10"; setcfg(1, 1, 1, 0, 0, 0, 8'hFF);
    base = vcount; run_frame(256, 2, 1, -1, 0); check_eq("R10", vcount - base, 8);
    // R6: framing bit plus 24 channels
    tag = "R6"; setcfg(1, 1, 1, 1, 0, 0, 8'hFF);
    base = vcount; run_frame(193, 0, 1, -1, 0); check_eq("R6 ch0", vcount - base, 8);
    setcfg(1, 1, 1, 1, 0, 23, 8'hFF);
    base = vcount; run_frame(193, 0, 1, -1, 0); check_eq("R6 ch23", vcount - base, 8);
    setcfg(1, 1, 1, 1, 0, 25, 8'hFF);
    base = vcount; run_frame(193, 0, 1, -1, 0); check_eq("R6 ch25", vcount - base, 0);
    // R7: gate closed
    tag = "R7"; setcfg(0, 1, 1, 0, 0, 3, 8'hFF);
    base = vcount; run_frame(256, 0, 1, -1, 0); check_eq("R7", vcount - base, 0);
    // R8: bypass, parity deselected and mask empty
    tag = "R8"; setcfg(1, 0, 0, 0, 1, 7, 8'h00); fs_mod = 4; fs_off = 1;
    base = vcount; repeat (2) run_frame(256, 0, 1, -1, 0); check_eq("R8", vcount - base, 128);
    fs_mod = 1000; fs_off = 999;
    // R9: mid-frame change toward an already passed timeslot
    tag = "R9"; setcfg(1, 1, 1, 0, 0, 4, 8'hFF);
    base = vcount; run_frame(256, 0, 1, 10, 3); check_eq("R9 held", vcount - base, 8);
    base = vcount; run_frame(256, 0, 1, -1, 0); check_eq("R9 next", vcount - base, 8);
    // R11: wrap without frame start
    tag = "R11"; setcfg(1, 1, 1, 0, 0, 1, 8'hFF);
    base = vcount; run_frame(256, 0, 1, -1, 0); run_frame(256, 0, 0, -1, 0);
    check_eq("R11", vcount - base, 16);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule